// File: doc/BRIEF.md
# Byte-Serial Memory Bus Sequencer

This block sits between a CPU core and an external bus whose data path is eight bits wide. The core asks for a 16-bit word or an 8-bit byte transfer, a read or a write, at a given address. The sequencer splits each external word transfer into two byte transfers: the high byte first, at the even address, then the low byte at the address with bit 0 set. A byte transfer uses only the first byte slot, and its address goes out unchanged. The external slave can stretch each data slot by holding READY low. As an option, the block can add one fixed wait cycle after every address slot. This option is chosen once, from the READY level in the cycle that follows reset release.

Two address windows never reach the bus. The first is a 256-byte scratch RAM in page 0xF0. The second is a 16-bit countdown-value register at 0xFFFA/0xFFFB. Accesses to either window finish in one internal pass and pay no attention to READY. An external master can take the bus with HOLD. The sequencer grants HOLDA only while no access is running, and it drops HOLDA as soon as HOLD is released.

The state machine has these states: INIT (reset processing), IDLE, HOLD (bus released), ADDR_HI, WAIT_HI, DATA_HI, ADDR_LO, WAIT_LO, DATA_LO, LOCAL (internal window pass) and DONE. The transitions are as follows:
- INIT goes to IDLE after one cycle and samples READY as it does so.
- IDLE goes to HOLD when HOLD is high. HOLD has priority over a request.
- Otherwise, on a request, IDLE goes to LOCAL for an internal window and to ADDR_HI for anything else.
- HOLD goes back to IDLE when HOLD falls.
- ADDR_HI goes to WAIT_HI in auto-wait mode and to DATA_HI otherwise. WAIT_HI goes to DATA_HI.
- DATA_HI stays put while READY is low. Once READY is high, it goes to ADDR_LO for a word and to DONE for a byte.
- ADDR_LO, WAIT_LO and DATA_LO behave like their high-byte counterparts, and DATA_LO goes to DONE.
- LOCAL goes to DONE.
- DONE goes to IDLE.

Top module: `byte_bus_sequencer`

## Requirements
- R1: A synchronous reset (rst high) puts the block in INIT. In INIT, and then in IDLE, core_done, bus_rd, bus_wr and bus_holda are all 0.
- R2: Auto-wait mode is enabled when bus_ready is low in the first clock after rst falls, and disabled otherwise. The bus_ready level while rst is high has no effect.
- R3: An external word access (core_word=1) transfers bits 15:8 at the even address {addr[15:1],0}, then bits 7:0 at {addr[15:1],1}. Without waits, core_done is high in the 5th cycle after the cycle in which the request is accepted.
- R4: An external byte access (core_word=0) makes one transfer at core_addr unchanged. The data is in bits 7:0, and a byte read returns 0 in core_rdata[15:8]. Without waits, core_done is high in the 3rd cycle.
- R5: In auto-wait mode, each address slot is followed by exactly one extra cycle. This gives a byte latency of 4 and a word latency of 7.
- R6: Each clock in which bus_ready is low during a data slot (bus_rd or bus_wr high) holds the slot and its address, and adds one cycle to the latency.
- R7: Addresses with bits 15:8 equal to 0xF0 access a 256-byte internal RAM in 2 cycles. They raise no bus strobe and ignore bus_ready. A word uses the even byte for bits 15:8 and the odd byte for bits 7:0.
- R8: Addresses 0xFFFA/0xFFFB access an internal 16-bit register in 2 cycles. A word access reads or writes all 16 bits. A byte access at 0xFFFA selects bits 15:8 and a byte access at 0xFFFB selects bits 7:0.
- R9: HOLD seen in IDLE raises bus_holda one cycle later. While bus_holda is high, bus_rd and bus_wr stay low and no request is started.
- R10: HOLD raised during an access leaves the access and its latency unchanged. bus_holda rises in the second cycle after core_done.
- R11: When HOLD falls, bus_holda falls one cycle later, and a request held pending during the hold is then carried out.
- R12: core_done is high for exactly one cycle per access, and core_rdata holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_req | input | 1 | Access request, held until core_done |
| core_addr | input | 16 | Byte address |
| core_wdata | input | 16 | Write data (bits 7:0 for bytes) |
| core_word | input | 1 | 1 = word, 0 = byte |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_rdata | output | 16 | Read result |
| core_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 16 | External bus address |
| bus_dout | output | 8 | External write data |
| bus_din | input | 8 | External read data |
| bus_rd | output | 1 | Read strobe, data slot |
| bus_wr | output | 1 | Write strobe, data slot |
| bus_ready | input | 1 | Slave ready; low stretches a data slot |
| bus_hold | input | 1 | External bus request |
| bus_holda | output | 1 | Bus released acknowledge |

## Verification
The bench checks that a word at an odd address lands on the even byte first. A sequencer that forced bit 0 wrongly, or swapped the byte order, would scramble the external bytes. It also checks that a byte write to an odd address leaves its even neighbour untouched. A HOLD raised in the middle of a stretched access must not grant the bus early: a grant taken inside the access would show up as bus_holda before core_done, or as a longer latency. Latencies are measured for several READY stall patterns, with auto-wait off and on. The auto-wait cases include one where READY changes while rst is still high, which a design that sampled READY during reset would get wrong. Internal-window accesses run with READY forced low, so a design that forgot to bypass READY would hang, or would show bus strobes there.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        S_INIT,
        S_IDLE,
        S_HOLD,
        S_ADDR_HI,
        S_WAIT_HI,
        S_DATA_HI,
        S_ADDR_LO,
        S_WAIT_LO,
        S_DATA_LO,
        S_LOCAL,
        S_DONE
    } bsq_state_e;

    typedef enum logic [1:0] {
        WIN_EXT,
        WIN_RAM,
        WIN_REG
    } bsq_win_e;
endpackage

// File: rtl/bsq_window.sv
module bsq_window
    import bsq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RAM_AW   = 8,
    parameter logic [ADDR_W-RAM_AW-1:0] RAM_PAGE = 'hF0,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFA
) (
    input  logic [ADDR_W-1:0] addr,
    output bsq_win_e          win
);
    logic hit_ram;
    logic hit_reg;

    always_comb begin
        hit_ram = (addr[ADDR_W-1:RAM_AW] == RAM_PAGE);
        hit_reg = (addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);
        if (hit_ram)      win = WIN_RAM;
        else if (hit_reg) win = WIN_REG;
        else              win = WIN_EXT;
    end
endmodule

// File: rtl/bsq_local_store.sv
module bsq_local_store
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr,
    input  logic              word,
    input  logic              sel_reg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] cnt_reg;
    logic [RAM_AW-1:0] idx_even;
    logic [RAM_AW-1:0] idx_odd;
    logic [RAM_AW-1:0] idx_byte;

    always_comb begin
        idx_byte = addr[RAM_AW-1:0];
        idx_even = {addr[RAM_AW-1:1], 1'b0};
        idx_odd  = {addr[RAM_AW-1:1], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (en && wr && !sel_reg) begin
            if (word) begin
                mem[idx_even] <= wdata[WORD_W-1:BYTE_W];
                mem[idx_odd]  <= wdata[BYTE_W-1:0];
            end else begin
                mem[idx_byte] <= wdata[BYTE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_reg <= '0;
        end else if (en && wr && sel_reg) begin
            if (word)
                cnt_reg <= wdata;
            else if (addr[0])
                cnt_reg[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
            else
                cnt_reg[WORD_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        if (sel_reg) begin
            if (word)         rdata = cnt_reg;
            else if (addr[0]) rdata = {{BYTE_W{1'b0}}, cnt_reg[BYTE_W-1:0]};
            else              rdata = {{BYTE_W{1'b0}}, cnt_reg[WORD_W-1:BYTE_W]};
        end else begin
            if (word) rdata = {mem[idx_even], mem[idx_odd]};
            else      rdata = {{BYTE_W{1'b0}}, mem[idx_byte]};
        end
    end
endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [WORD_W-1:0] core_wdata,
    input  logic              core_word,
    input  logic              core_wr,
    input  bsq_win_e          core_win,
    output logic [WORD_W-1:0] core_rdata,
    output logic              core_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_dout,
    input  logic [BYTE_W-1:0] bus_din,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready,
    input  logic              bus_hold,
    output logic              bus_holda,
    output logic              st_en,
    output logic              st_wr,
    output logic              st_word,
    output logic              st_sel_reg,
    output logic [ADDR_W-1:0] st_addr,
    output logic [WORD_W-1:0] st_wdata,
    input  logic [WORD_W-1:0] st_rdata
);
    bsq_state_e        state, state_nx;
    logic              auto_q;
    logic [ADDR_W-1:0] a_q;
    logic [WORD_W-1:0] w_q;
    logic              word_q;
    logic              wr_q;
    bsq_win_e          win_q;
    logic [WORD_W-1:0] res_q;
    logic              data_slot;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_INIT;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_INIT:    state_nx = S_IDLE;
            S_IDLE: begin
                if (bus_hold)
                    state_nx = S_HOLD;
                else if (core_req)
                    state_nx = (core_win == WIN_EXT) ? S_ADDR_HI : S_LOCAL;
            end
            S_HOLD:    if (!bus_hold) state_nx = S_IDLE;
            S_ADDR_HI: state_nx = auto_q ? S_WAIT_HI : S_DATA_HI;
            S_WAIT_HI: state_nx = S_DATA_HI;
            S_DATA_HI: if (bus_ready) state_nx = word_q ? S_ADDR_LO : S_DONE;
            S_ADDR_LO: state_nx = auto_q ? S_WAIT_LO : S_DATA_LO;
            S_WAIT_LO: state_nx = S_DATA_LO;
            S_DATA_LO: if (bus_ready) state_nx = S_DONE;
            S_LOCAL:   state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_INIT;
        endcase
    end

    // Request capture, auto-wait mode and read assembly
    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q <= 1'b0;
            a_q    <= '0;
            w_q    <= '0;
            word_q <= 1'b0;
            wr_q   <= 1'b0;
            win_q  <= WIN_EXT;
            res_q  <= '0;
        end else begin
            if (state == S_INIT)
                auto_q <= !bus_ready;
            if (state == S_IDLE && !bus_hold && core_req) begin
                a_q    <= core_addr;
                w_q    <= core_wdata;
                word_q <= core_word;
                wr_q   <= core_wr;
                win_q  <= core_win;
                res_q  <= '0;
            end
            if (state == S_DATA_HI && bus_ready && !wr_q) begin
                if (word_q) res_q[WORD_W-1:BYTE_W] <= bus_din;
                else        res_q <= {{BYTE_W{1'b0}}, bus_din};
            end
            if (state == S_DATA_LO && bus_ready && !wr_q)
                res_q[BYTE_W-1:0] <= bus_din;
            if (state == S_LOCAL && !wr_q)
                res_q <= st_rdata;
        end
    end

    // Outputs
    always_comb begin
        data_slot  = (state == S_DATA_HI) || (state == S_DATA_LO);
        bus_rd     = data_slot && !wr_q;
        bus_wr     = data_slot && wr_q;
        bus_holda  = (state == S_HOLD);
        core_done  = (state == S_DONE);
        core_rdata = res_q;
        bus_addr   = '0;
        bus_dout   = '0;
        unique case (state)
            S_ADDR_HI, S_WAIT_HI, S_DATA_HI: begin
                bus_addr = word_q ? {a_q[ADDR_W-1:1], 1'b0} : a_q;
                if (state == S_DATA_HI && wr_q)
                    bus_dout = word_q ? w_q[WORD_W-1:BYTE_W] : w_q[BYTE_W-1:0];
            end
            S_ADDR_LO, S_WAIT_LO, S_DATA_LO: begin
                bus_addr = {a_q[ADDR_W-1:1], 1'b1};
                if (state == S_DATA_LO && wr_q)
                    bus_dout = w_q[BYTE_W-1:0];
            end
            default: begin
                bus_addr = '0;
                bus_dout = '0;
            end
        endcase
        st_en      = (state == S_LOCAL);
        st_wr      = wr_q;
        st_word    = word_q;
        st_sel_reg = (win_q == WIN_REG);
        st_addr    = a_q;
        st_wdata   = w_q;
    end

    // Assertions
    a_r6_ready_stall: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA_HI && !bus_ready) |=> (state == S_DATA_HI && $stable(bus_addr)));
    a_r6_ready_stall_lo: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA_LO && !bus_ready) |=> (state == S_DATA_LO && $stable(bus_addr)));
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        core_done |=> !core_done);
    a_r9_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
        bus_holda |-> !(bus_rd || bus_wr));
    a_r10_grant_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_holda) |-> $past(state == S_IDLE));
    a_r3_low_slot_odd: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA_LO) |-> bus_addr[0]);
    a_r7_local_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOCAL) |-> !(bus_rd || bus_wr));
endmodule

// File: rtl/byte_bus_sequencer.sv
module byte_bus_sequencer
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 8,
    parameter logic [ADDR_W-RAM_AW-1:0] RAM_PAGE = 'hF0,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [15:0]       core_wdata,
    input  logic              core_word,
    input  logic              core_wr,
    output logic [15:0]       core_rdata,
    output logic              core_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    input  logic [7:0]        bus_din,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready,
    input  logic              bus_hold,
    output logic              bus_holda
);
    bsq_win_e          win;
    logic              st_en, st_wr, st_word, st_sel_reg;
    logic [ADDR_W-1:0] st_addr;
    logic [WORD_W-1:0] st_wdata, st_rdata;

    bsq_window #(
        .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .RAM_PAGE(RAM_PAGE), .REG_ADDR(REG_ADDR)
    ) u_window (
        .addr(core_addr),
        .win (win)
    );

    bsq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .core_req  (core_req),
        .core_addr (core_addr),
        .core_wdata(core_wdata),
        .core_word (core_word),
        .core_wr   (core_wr),
        .core_win  (win),
        .core_rdata(core_rdata),
        .core_done (core_done),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_din   (bus_din),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_ready (bus_ready),
        .bus_hold  (bus_hold),
        .bus_holda (bus_holda),
        .st_en     (st_en),
        .st_wr     (st_wr),
        .st_word   (st_word),
        .st_sel_reg(st_sel_reg),
        .st_addr   (st_addr),
        .st_wdata  (st_wdata),
        .st_rdata  (st_rdata)
    );

    bsq_local_store #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .en     (st_en),
        .wr     (st_wr),
        .word   (st_word),
        .sel_reg(st_sel_reg),
        .addr   (st_addr),
        .wdata  (st_wdata),
        .rdata  (st_rdata)
    );
endmodule

// File: tb/test_byte_bus_sequencer.sv
`timescale 1ns/1ps
module test_byte_bus_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_req = 1'b0;
    logic [15:0] c_addr = '0;
    logic [15:0] c_wdata = '0;
    logic        c_word = 1'b0;
    logic        c_wr = 1'b0;
    logic [15:0] c_rdata;
    logic        c_done;
    logic [15:0] b_addr;
    logic [7:0]  b_dout;
    logic [7:0]  b_din;
    logic        b_rd, b_wr, b_ready, b_holda;
    logic        b_hold = 1'b0;
    logic        rdy_r = 1'b1;
    logic        force_lo = 1'b0;
    int          stall_n = 0;
    int          st_cnt = 0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  ext [256];

    logic [15:0] q_exp [$];
    int          q_lat [$];
    int          q_start [$];
    bit          q_rd [$];
    string       q_tag [$];
    bit          chk_next = 1'b0;

    always #2.5 clk = ~clk;

    byte_bus_sequencer i_byte_bus_sequencer (
        .clk(clk), .rst(rst), .core_req(c_req), .core_addr(c_addr),
        .core_wdata(c_wdata), .core_word(c_word), .core_wr(c_wr),
        .core_rdata(c_rdata), .core_done(c_done), .bus_addr(b_addr),
        .bus_dout(b_dout), .bus_din(b_din), .bus_rd(b_rd), .bus_wr(b_wr),
        .bus_ready(b_ready), .bus_hold(b_hold), .bus_holda(b_holda)
    );

    // External byte memory and READY model
    assign b_din   = ext[b_addr[7:0]];
    assign b_ready = force_lo ? 1'b0 : rdy_r;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (b_wr && b_ready) ext[b_addr[7:0]] <= b_dout;
    end

    always @(negedge clk) begin
        if ((b_rd || b_wr) && st_cnt < stall_n) begin
            rdy_r  = 1'b0;
            st_cnt = st_cnt + 1;
        end else begin
            rdy_r = 1'b1;
            if (!(b_rd || b_wr)) st_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (chk_next) begin
            chk(!c_done, "R12 done width", {31'd0, c_done}, 32'd0);
            chk_next = 1'b0;
        end
        if (!rst && c_done) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "R12 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [15:0] e;
                int l, s;
                bit r;
                string t;
                e = q_exp.pop_front(); l = q_lat.pop_front(); s = q_start.pop_front();
                r = q_rd.pop_front();  t = q_tag.pop_front();
                if (r) chk(c_rdata == e, {t, " read data"}, {16'd0, c_rdata}, {16'd0, e});
                if (l >= 0) chk((cyc - s) == l, {t, " latency"}, cyc - s, l);
                chk_next = 1'b1;
            end
        end
    end

    // Driver
    task automatic access(input logic [15:0] a, input bit wd, input bit wr,
                          input logic [15:0] wv, input logic [15:0] exp,
                          input int lat, input string tag);
        @(negedge clk);
        c_addr = a; c_word = wd; c_wr = wr; c_wdata = wv;
        q_exp.push_back(exp); q_lat.push_back(lat); q_start.push_back(cyc);
        q_rd.push_back(!wr);  q_tag.push_back(tag);
        c_req = 1'b1;
        do @(negedge clk); while (!c_done);
        c_req = 1'b0;
    endtask

    task automatic do_reset(input bit lo_during, input bit lo_release);
        @(negedge clk);
        rst = 1'b1; force_lo = lo_during;
        repeat (3) @(negedge clk);
        rst = 1'b0; force_lo = lo_release;
        @(negedge clk);
        force_lo = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ext[i] = 8'(i * 7 + 3);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: post-reset quiet outputs
        chk(!c_done && !b_holda && !b_rd && !b_wr, "R1 reset outputs",
            {28'd0, c_done, b_holda, b_rd, b_wr}, 32'd0);
        @(negedge clk);
        chk(!c_done && !b_rd && !b_wr, "R1 idle outputs", {29'd0, c_done, b_rd, b_wr}, 32'd0);

        // R3: word reads, even and odd address
        access(16'h0010, 1, 0, 0, {ext[8'h10], ext[8'h11]}, 5, "R3 word read even");
        access(16'h0021, 1, 0, 0, {ext[8'h20], ext[8'h21]}, 5, "R3 word read odd");
        access(16'h0031, 1, 1, 16'hBEEF, 0, 5, "R3 word write");
        chk(ext[8'h30] == 8'hBE, "R3 high byte at even", ext[8'h30], 8'hBE);
        chk(ext[8'h31] == 8'hEF, "R3 low byte at odd", ext[8'h31], 8'hEF);
        access(16'h0030, 1, 0, 0, 16'hBEEF, 5, "R3 word readback");

        // R4: byte accesses keep address bit 0
        access(16'h0013, 0, 0, 0, {8'h00, ext[8'h13]}, 3, "R4 byte read odd");
        begin
            logic [7:0] nb;
            nb = ext[8'h40];
            access(16'h0041, 0, 1, 16'h77C3, 0, 3, "R4 byte write odd");
            chk(ext[8'h41] == 8'hC3, "R4 byte lands odd", ext[8'h41], 8'hC3);
            chk(ext[8'h40] == nb, "R4 even neighbour kept", ext[8'h40], nb);
        end

        // R6: READY stalls
        stall_n = 2;
        access(16'h0050, 1, 0, 0, {ext[8'h50], ext[8'h51]}, 9, "R6 word stalled");
        access(16'h0055, 0, 0, 0, {8'h00, ext[8'h55]}, 5, "R6 byte stalled");
        stall_n = 0;

        // R7: internal RAM, READY forced low
        begin
            logic [7:0] e10;
            e10 = ext[8'h10];
            force_lo = 1'b1;
            access(16'hF010, 1, 1, 16'h1234, 0, 2, "R7 ram word write");
            access(16'hF010, 1, 0, 0, 16'h1234, 2, "R7 ram word read");
            access(16'hF011, 0, 0, 0, 16'h0034, 2, "R7 ram byte read");
            access(16'hF0FF, 0, 1, 16'h00A9, 0, 2, "R7 ram byte write");
            access(16'hF0FE, 1, 0, 0, {8'h00, 8'hA9} | (16'h0000), -1, "R7 ram top word");
            force_lo = 1'b0;
            chk(ext[8'h10] == e10, "R7 external untouched", ext[8'h10], e10);
        end

        // R8: internal register window
        access(16'hFFFA, 1, 1, 16'hA55A, 0, 2, "R8 reg word write");
        access(16'hFFFA, 1, 0, 0, 16'hA55A, 2, "R8 reg word read");
        access(16'hFFFB, 0, 0, 0, 16'h005A, 2, "R8 reg byte low");
        access(16'hFFFA, 0, 1, 16'h003C, 0, 2, "R8 reg byte high write");
        access(16'hFFFA, 1, 0, 0, 16'h3C5A, 2, "R8 reg after byte write");

        // R9/R11: hold from idle, pending request served after release
        @(negedge clk);
        b_hold = 1'b1;
        @(negedge clk);
        chk(b_holda, "R9 holda granted", {31'd0, b_holda}, 32'd1);
        fork
            access(16'h0060, 1, 0, 0, {ext[8'h60], ext[8'h61]}, -1, "R11 pending request");
            begin
                repeat (4) @(negedge clk);
                chk(b_holda && !c_done && !b_rd, "R9 no access in hold",
                    {29'd0, b_holda, c_done, b_rd}, 32'd4);
                b_hold = 1'b0;
                @(negedge clk);
                chk(!b_holda, "R11 holda cleared", {31'd0, b_holda}, 32'd0);
            end
        join

        // R10: hold raised mid access
        stall_n = 3;
        fork
            access(16'h0070, 1, 0, 0, {ext[8'h70], ext[8'h71]}, 11, "R10 access under hold");
            begin
                repeat (3) @(negedge clk);
                b_hold = 1'b1;
                while (!c_done) begin
                    chk(!b_holda, "R10 no early grant", {31'd0, b_holda}, 32'd0);
                    @(negedge clk);
                end
                @(negedge clk);
                chk(!b_holda, "R10 idle before grant", {31'd0, b_holda}, 32'd0);
                @(negedge clk);
                chk(b_holda, "R10 grant after access", {31'd0, b_holda}, 32'd1);
                b_hold = 1'b0;
                @(negedge clk);
            end
        join
        stall_n = 0;

        // R2/R5: auto-wait selection
        do_reset(1'b1, 1'b0);
        access(16'h0080, 0, 0, 0, {8'h00, ext[8'h80]}, 3, "R2 low during reset ignored");
        do_reset(1'b0, 1'b1);
        access(16'h0081, 0, 0, 0, {8'h00, ext[8'h81]}, 4, "R5 auto byte");
        access(16'h0082, 1, 0, 0, {ext[8'h82], ext[8'h83]}, 7, "R5 auto word");
        access(16'hFFFA, 1, 0, 0, 16'h0000, 2, "R5 auto local unaffected");
        stall_n = 1;
        access(16'h0090, 1, 0, 0, {ext[8'h90], ext[8'h91]}, 9, "R2 auto plus stall");
        stall_n = 0;

        repeat (3) @(negedge clk);
        chk(q_exp.size() == 0, "R12 all accesses done", q_exp.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule